// File: doc/BRIEF.md
# Display Bus Bridge

This block sits between a processor's memory-mapped bus and the parallel port of a character display controller. A processor transfer is captured in one clock: the direction, the register-select line and the write data. It is then replayed to the display as a timed bus cycle with three phases. In the setup phase the select and direction lines settle. In the strobe phase the enable line is high. In the hold phase the enable line is low again and the other lines stay put.

A shift-register chain runs the three phases, and each phase length is a parameter. The processor's transfer acknowledge is held back until the hold phase has ended. On writes the bridge drives the display data lines. On reads it releases them, so the controller can drive them. This lets software poll the display's busy flag with an ordinary load. The value read is captured just before the enable line falls and is returned with the acknowledge. The pad enable output and the pad input are meant to drive a tri-state pad outside the block.

Top module: `lcd_bus_bridge`

## Requirements
- R1: After reset, `lcd_en`, `lcd_data_oe` and `cpu_ack` are 0, `lcd_rw` is 1 (read direction) and `lcd_wdata` is 0.
- R2: A write drives `lcd_data_oe` high for every cycle of the display sequence (cycles 0 to TOTAL-1 after the accepting edge), and `lcd_wdata` carries the captured `cpu_wdata` throughout.
- R3: A read keeps `lcd_data_oe` low for the whole sequence. `lcd_rw` is 0 for a write (`cpu_we`=1) and 1 for a read (`cpu_we`=0).
- R4: `lcd_rs` equals the `cpu_reg_sel` value captured with the request (0 = instruction register, 1 = data register) for the whole sequence.
- R5: `lcd_en` is low for the first SETUP_CYC sequence cycles. It is then high for exactly STROBE_CYC cycles.
- R6: `lcd_en` is low for the HOLD_CYC cycles that follow the strobe. `cpu_ack` is then high for exactly one cycle, TOTAL = SETUP_CYC+STROBE_CYC+HOLD_CYC edges after the accepting edge, with `lcd_en` and `lcd_data_oe` low.
- R7: On a read, `cpu_rdata` during the acknowledge cycle equals the value on `lcd_rdata_in` in the last strobe-high cycle. Values in other cycles have no effect.
- R8: Changes to `cpu_we`, `cpu_reg_sel` and `cpu_wdata` after the accepting edge do not change `lcd_rw`, `lcd_rs` or `lcd_wdata` during that sequence.
- R9: `cpu_req` is ignored from the accepting edge through the acknowledge cycle. A request held high across that span starts no extra sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor transfer request, sampled on the rising edge while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_reg_sel | input | 1 | Address line choosing instruction (0) or data (1) register |
| cpu_wdata | input | DW | Processor write data |
| cpu_ack | output | 1 | One-cycle transfer acknowledge |
| cpu_rdata | output | DW | Read data, valid with `cpu_ack` on reads |
| lcd_rs | output | 1 | Display register select |
| lcd_rw | output | 1 | Display direction, 1 = read |
| lcd_en | output | 1 | Display enable strobe |
| lcd_wdata | output | DW | Value for the display data pads |
| lcd_data_oe | output | 1 | Pad output enable, 1 = bridge drives the data lines |
| lcd_rdata_in | input | DW | Value seen on the display data pads |

## Verification
Call the rising edge that accepts a request edge 0. Sequence cycle k is visible after edge k. The enable is expected exactly in cycles SETUP_CYC through SETUP_CYC+STROBE_CYC-1, and the acknowledge with read data after edge TOTAL. The bench drives inputs and samples outputs on falling edges, one sample per sequence cycle, so each expectation is compared in the cycle its register updates. The pad input holds the wanted value only in the last strobe cycle and its complement elsewhere. Inverted processor inputs and a held request are applied throughout each sequence, which exposes a sample taken in the wrong cycle and any leak of the live processor inputs.

// File: rtl/lcd_bridge_pkg.sv
package lcd_bridge_pkg;

    // Per-cycle view of the display sequence, produced by the sequencer.
    typedef struct packed {
        logic active;   // a sequence stage is running
        logic idle;     // no stage and no acknowledge pending
        logic strobe;   // display enable level
        logic sample;   // last strobe-high stage: capture read data
        logic done;     // acknowledge cycle
    } seq_flags_t;

endpackage

// File: rtl/lcd_bridge_seq.sv
module lcd_bridge_seq
    import lcd_bridge_pkg::*;
#(
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 4,
    parameter int HOLD_CYC   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output seq_flags_t flags
);

    localparam int TOTAL       = SETUP_CYC + STROBE_CYC + HOLD_CYC;
    localparam int LAST_STROBE = SETUP_CYC + STROBE_CYC - 1;

    // Stage positions where the enable is high.
    logic [TOTAL-1:0] strobe_mask;
    for (genvar i = 0; i < TOTAL; i++) begin : g_mask
        assign strobe_mask[i] = ((i >= SETUP_CYC) && (i <= LAST_STROBE)) ? 1'b1 : 1'b0;
    end

    typedef struct packed {
        logic [TOTAL-1:0] chain;  // one-hot token marching through stages
        logic             strobe;
        logic             done;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       busy;

    assign busy = (|st_q.chain) | st_q.done;

    always_comb begin
        st_d        = st_q;
        st_d.chain  = {st_q.chain[TOTAL-2:0], start & ~busy};
        st_d.strobe = |(st_d.chain & strobe_mask);
        st_d.done   = st_q.chain[TOTAL-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        flags        = '0;
        flags.active = |st_q.chain;
        flags.idle   = ~busy;
        flags.strobe = st_q.strobe;
        flags.sample = st_q.chain[LAST_STROBE];
        flags.done   = st_q.done;
    end

endmodule

// File: rtl/lcd_bridge_capture.sv
module lcd_bridge_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          sample,
    input  logic          wr_in,
    input  logic          sel_in,
    input  logic [DW-1:0] wdata_in,
    input  logic [DW-1:0] bus_in,
    output logic          wr,
    output logic          sel,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    typedef struct packed {
        logic          wr;
        logic          sel;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.wr    = wr_in;
            st_d.sel   = sel_in;
            st_d.wdata = wdata_in;
        end
        if (sample && !st_q.wr) begin
            st_d.rdata = bus_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr    = st_q.wr;
    assign sel   = st_q.sel;
    assign wdata = st_q.wdata;
    assign rdata = st_q.rdata;

endmodule

// File: rtl/lcd_bus_bridge.sv
module lcd_bus_bridge
    import lcd_bridge_pkg::*;
#(
    parameter int DW         = 8,
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 4,
    parameter int HOLD_CYC   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic          cpu_reg_sel,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_ack,
    output logic [DW-1:0] cpu_rdata,
    output logic          lcd_rs,
    output logic          lcd_rw,
    output logic          lcd_en,
    output logic [DW-1:0] lcd_wdata,
    output logic          lcd_data_oe,
    input  logic [DW-1:0] lcd_rdata_in
);

    seq_flags_t flags;
    logic       accept;
    logic       cap_wr;
    logic       cap_sel;

    assign accept = cpu_req & flags.idle;

    lcd_bridge_seq #(
        .SETUP_CYC (SETUP_CYC),
        .STROBE_CYC(STROBE_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .start(accept),
        .flags(flags)
    );

    lcd_bridge_capture #(
        .DW(DW)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .sample  (flags.sample),
        .wr_in   (cpu_we),
        .sel_in  (cpu_reg_sel),
        .wdata_in(cpu_wdata),
        .bus_in  (lcd_rdata_in),
        .wr      (cap_wr),
        .sel     (cap_sel),
        .wdata   (lcd_wdata),
        .rdata   (cpu_rdata)
    );

    assign lcd_rs      = cap_sel;
    assign lcd_rw      = ~cap_wr;
    assign lcd_en      = flags.strobe;
    assign lcd_data_oe = flags.active & cap_wr;
    assign cpu_ack     = flags.done;

endmodule

// File: rtl/lcd_bus_bridge_chk.sv
module lcd_bus_bridge_chk #(
    parameter int DW         = 8,
    parameter int STROBE_CYC = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lcd_en,
    input logic          lcd_rs,
    input logic          lcd_rw,
    input logic          lcd_data_oe,
    input logic [DW-1:0] lcd_wdata,
    input logic          cpu_ack
);

    logic [31:0] en_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_run_q <= '0;
        end else if (lcd_en) begin
            en_run_q <= en_run_q + 32'd1;
        end else begin
            en_run_q <= '0;
        end
    end

    // R5
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_en) |-> en_run_q == 32'(STROBE_CYC));

    // R5
    strobe_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_en |-> en_run_q < 32'(STROBE_CYC));

    // R6
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

    // R6
    ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> !lcd_en && !lcd_data_oe);

    // R4
    setup_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_en) |-> $stable(lcd_rs) && $stable(lcd_rw));

    // R8
    strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_en && $past(lcd_en) |-> $stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_wdata));

endmodule

bind lcd_bus_bridge lcd_bus_bridge_chk #(
    .DW        (DW),
    .STROBE_CYC(STROBE_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lcd_en     (lcd_en),
    .lcd_rs     (lcd_rs),
    .lcd_rw     (lcd_rw),
    .lcd_data_oe(lcd_data_oe),
    .lcd_wdata  (lcd_wdata),
    .cpu_ack    (cpu_ack)
);

// File: tb/lcd_bus_bridge_bench.sv
`timescale 1ns/1ps
module lcd_bus_bridge_bench;

    localparam int DW     = 8;
    localparam int SETUP  = 2;
    localparam int STROBE = 4;
    localparam int HOLD   = 2;
    localparam int TOTAL  = SETUP + STROBE + HOLD;
    localparam int LAST   = SETUP + STROBE - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic          cpu_reg_sel = 1'b0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ack;
    logic [DW-1:0] cpu_rdata;
    logic          lcd_rs;
    logic          lcd_rw;
    logic          lcd_en;
    logic [DW-1:0] lcd_wdata;
    logic          lcd_data_oe;
    logic [DW-1:0] lcd_rdata_in = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    lcd_bus_bridge #(
        .DW(DW), .SETUP_CYC(SETUP), .STROBE_CYC(STROBE), .HOLD_CYC(HOLD)
    ) u_lcd_bus_bridge (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_reg_sel(cpu_reg_sel), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
        .cpu_rdata(cpu_rdata), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en),
        .lcd_wdata(lcd_wdata), .lcd_data_oe(lcd_data_oe), .lcd_rdata_in(lcd_rdata_in)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic sel, input logic [DW-1:0] wd,
                        input logic [DW-1:0] rv);
        @(negedge clk);
        cpu_req     = 1'b1;
        cpu_we      = wr;
        cpu_reg_sel = sel;
        cpu_wdata   = wd;
        for (int k = 0; k <= TOTAL; k++) begin
            @(negedge clk);
            if (k < TOTAL) begin
                check("R5 enable phase", 32'(lcd_en), 32'((k >= SETUP) && (k <= LAST)));
                check("R2/R3 pad drive", 32'(lcd_data_oe), 32'(wr));
                check("R3 direction", 32'(lcd_rw), 32'(!wr));
                check("R4 select", 32'(lcd_rs), 32'(sel));
                if (wr) check("R2 write data", 32'(lcd_wdata), 32'(wd));
                check("R6 no early ack", 32'(cpu_ack), 32'd0);
                // R8 R9: busy-time request with inverted fields
                cpu_req     = 1'b1;
                cpu_we      = !wr;
                cpu_reg_sel = !sel;
                cpu_wdata   = ~wd;
            end else begin
                check("R6 ack", 32'(cpu_ack), 32'd1);
                check("R6 en low at ack", 32'(lcd_en), 32'd0);
                check("R6 pads off at ack", 32'(lcd_data_oe), 32'd0);
                if (!wr) check("R7 read data", 32'(cpu_rdata), 32'(rv));
                cpu_req = 1'b0;
            end
            lcd_rdata_in = (k == LAST) ? rv : ~rv;
        end
        @(negedge clk);
        check("R9 no extra ack", 32'(cpu_ack), 32'd0);
        check("R9 no extra strobe", 32'(lcd_en), 32'd0);
        check("R9 no extra drive", 32'(lcd_data_oe), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ack", 32'(cpu_ack), 32'd0);
        check("R1 en", 32'(lcd_en), 32'd0);
        check("R1 oe", 32'(lcd_data_oe), 32'd0);
        check("R1 rw", 32'(lcd_rw), 32'd1);
        check("R1 wdata", 32'(lcd_wdata), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int d = 0; d < 32; d++) begin
            for (int m = 0; m < 4; m++) begin
                logic [DW-1:0] val;
                val = DW'((d * 37 + 11) ^ (m << 6));
                xfer(m[0], m[1], val, ~val ^ DW'(d));
            end
        end
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule